// File: doc/BRIEF.md
# Power State Request Controller

This block is the controller end of a four-wire power-state handshake. Local logic asks for a device to move to a target power state. The block then drives a registered request line and a registered M-bit state code toward the device. It waits for the device to grant or refuse, closes the handshake, and reports the result with single-cycle status pulses. It keeps a copy of the last granted state. When the device refuses, it puts the state code back to that granted value in the same cycle that the request line drops.

After reset is released, the block holds the state code at its reset value and raises no request for a fixed number of initialization cycles (`TINIT`), so that the device can capture it. A request that arrives while a handshake is still open is kept and started once the channel is quiet again. If several such requests arrive, the newest one is kept. The block also samples the device's N-bit activity vector. When automatic mode is enabled and no explicit request is waiting, it asks for the state that the highest set activity bit names.

Top module: `pwr_req_ctrl`

## Requirements
- R1: While rst_ni is low: preq_o is 0, pstate_o and cur_state_o equal INIT_STATE (default 1), and done_o and denied_o are 0.
- R2: For the first TINIT clock edges after rst_ni rises, preq_o stays 0 and pstate_o keeps INIT_STATE, even if start_i is held high.
- R3: A start_i sampled while the block is ready, idle and both device responses are low sets preq_o to 1 and pstate_o to target_i on the same edge. pstate_o does not change while preq_o stays high.
- R4: preq_o rises only on an edge where paccept_i and pdeny_i were both sampled low.
- R5: preq_o falls on the edge after exactly one of paccept_i or pdeny_i is sampled high. If both are high, preq_o stays high.
- R6: On a refusal, pstate_o returns to cur_state_o on the edge where preq_o falls, and cur_state_o does not change. Once pdeny_i is sampled low, denied_o pulses for one cycle.
- R7: On a grant, cur_state_o takes the requested state and done_o pulses for one cycle, on the edge after paccept_i is sampled low. cur_state_o changes on no other edge.
- R8: A start_i that cannot launch at once (handshake open or block not yet ready) is stored, with later ones replacing earlier ones. It launches on the first edge at which the channel is quiet.
- R9: With auto_en_i high, after pactive_i has passed through one register stage, bit k set (highest set bit wins) asks for state k when that state differs from cur_state_o. A start_i on the same edge takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, shared with the device |
| start_i | input | 1 | Request strobe from local logic |
| target_i | input | M | Requested power state |
| auto_en_i | input | 1 | Enable requests derived from the activity vector |
| pactive_i | input | N | Device activity vector |
| preq_o | output | 1 | Registered request line to the device |
| pstate_o | output | M | Registered state code to the device |
| paccept_i | input | 1 | Device grant |
| pdeny_i | input | 1 | Device refusal |
| cur_state_o | output | M | Last granted state |
| done_o | output | 1 | One-cycle pulse: a grant has completed |
| denied_o | output | 1 | One-cycle pulse: a refusal has completed |

## Verification
The properties assume the device keeps its side of the protocol. It never drives paccept_i and pdeny_i high together. It raises either one only while preq_o is high, and lowers it only after preq_o is low. It also sees reset only while the channel is idle. The bench drives the two response lines from a device model that answers only to a high request and releases only after the request drops, with a random delay for each phase. Reset is applied only at the start of the run, before any handshake is open.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2,
    ST_DNY  = 2'd3
  } hs_state_e;
endpackage

// File: rtl/pwr_tinit_wait.sv
module pwr_tinit_wait #(
  parameter int unsigned TINIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int unsigned CW = (TINIT > 1) ? $clog2(TINIT) : 1;

  logic [CW-1:0] cnt_q;
  logic          ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      if (cnt_q == CW'(TINIT - 1)) ready_q <= 1'b1;
      else                         cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/pwr_active_map.sv
module pwr_active_map #(
  parameter int unsigned N = 3,
  parameter int unsigned M = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pactive_i,
  output logic         want_v_o,
  output logic [M-1:0] want_state_o
);
  logic [N-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= pactive_i;
  end

  // highest set bit wins
  always_comb begin
    want_state_o = '0;
    for (int k = 0; k < int'(N); k++) begin
      if (act_q[k]) want_state_o = M'(k);
    end
  end

  assign want_v_o = |act_q;
endmodule

// File: rtl/pwr_req_hold.sv
module pwr_req_hold #(
  parameter int unsigned M = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic [M-1:0] tgt_i,
  input  logic         clear_i,
  output logic         pend_v_o,
  output logic [M-1:0] pend_tgt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_o   <= 1'b0;
      pend_tgt_o <= '0;
    end else if (clear_i) begin
      pend_v_o   <= 1'b0;
    end else if (capture_i) begin
      pend_v_o   <= 1'b1;
      pend_tgt_o <= tgt_i;
    end
  end
endmodule

// File: rtl/pwr_req_ctrl.sv
module pwr_req_ctrl
  import pwr_req_pkg::*;
#(
  parameter int unsigned M          = 2,
  parameter int unsigned N          = 3,
  parameter int unsigned TINIT      = 8,
  parameter int unsigned INIT_STATE = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [M-1:0] target_i,
  input  logic         auto_en_i,
  input  logic [N-1:0] pactive_i,
  output logic         preq_o,
  output logic [M-1:0] pstate_o,
  input  logic         paccept_i,
  input  logic         pdeny_i,
  output logic [M-1:0] cur_state_o,
  output logic         done_o,
  output logic         denied_o
);
  localparam logic [M-1:0] RST_STATE = M'(INIT_STATE);

  hs_state_e    st_q;
  logic         preq_q, done_q, denied_q;
  logic [M-1:0] pstate_q, cur_q;

  logic         ready, want_v, pend_v;
  logic [M-1:0] want_state, pend_tgt, launch_tgt;
  logic         quiet, auto_req, launch, capture;

  pwr_tinit_wait #(.TINIT(TINIT)) u_tinit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ready_o(ready)
  );

  pwr_active_map #(.N(N), .M(M)) u_amap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pactive_i   (pactive_i),
    .want_v_o    (want_v),
    .want_state_o(want_state)
  );

  pwr_req_hold #(.M(M)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .tgt_i     (target_i),
    .clear_i   (launch),
    .pend_v_o  (pend_v),
    .pend_tgt_o(pend_tgt)
  );

  assign quiet    = ready && (st_q == ST_IDLE) && !paccept_i && !pdeny_i;
  assign auto_req = auto_en_i && want_v && (want_state != cur_q);
  assign launch   = quiet && (start_i || pend_v || auto_req);
  assign capture  = start_i && !quiet;

  always_comb begin
    if (start_i)     launch_tgt = target_i;
    else if (pend_v) launch_tgt = pend_tgt;
    else             launch_tgt = want_state;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      preq_q   <= 1'b0;
      pstate_q <= RST_STATE;
      cur_q    <= RST_STATE;
      done_q   <= 1'b0;
      denied_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      denied_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (launch) begin
          pstate_q <= launch_tgt;
          preq_q   <= 1'b1;
          st_q     <= ST_REQ;
        end
        ST_REQ: begin
          if (paccept_i && !pdeny_i) begin
            preq_q <= 1'b0;
            st_q   <= ST_ACK;
          end else if (pdeny_i && !paccept_i) begin
            preq_q   <= 1'b0;
            pstate_q <= cur_q;  // restore on refusal
            st_q     <= ST_DNY;
          end
        end
        ST_ACK: if (!paccept_i) begin
          cur_q  <= pstate_q;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        ST_DNY: if (!pdeny_i) begin
          denied_q <= 1'b1;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign preq_o      = preq_q;
  assign pstate_o    = pstate_q;
  assign cur_state_o = cur_q;
  assign done_o      = done_q;
  assign denied_o    = denied_q;
endmodule

// File: rtl/pwr_req_ctrl_chk.sv
module pwr_req_ctrl_chk #(
  parameter int unsigned M          = 2,
  parameter int unsigned TINIT      = 8,
  parameter int unsigned INIT_STATE = 1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         preq_o,
  input logic [M-1:0] pstate_o,
  input logic         paccept_i,
  input logic         pdeny_i,
  input logic [M-1:0] cur_state_o,
  input logic         done_o,
  input logic         denied_o
);
  localparam int unsigned CW = $clog2(TINIT + 2);

  logic [CW-1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        since_rst <= '0;
    else if (since_rst != CW'(TINIT))   since_rst <= since_rst + 1'b1;
  end

  p_tinit_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < CW'(TINIT)) |-> (!preq_o && pstate_o == M'(INIT_STATE)));

  p_state_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preq_o && $past(preq_o)) |-> $stable(pstate_o));

  p_rise_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(preq_o) |-> $past(!paccept_i && !pdeny_i));

  p_fall_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(preq_o) |-> $past(paccept_i ^ pdeny_i));

  p_deny_revert_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(preq_o) && $past(pdeny_i)) |-> (pstate_o == cur_state_o));

  p_cur_on_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_state_o) |-> done_o);

  p_status_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && denied_o));

  p_done_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || denied_o) |-> ($past(!paccept_i && !pdeny_i) && !preq_o));
endmodule

bind pwr_req_ctrl pwr_req_ctrl_chk #(
  .M(M), .TINIT(TINIT), .INIT_STATE(INIT_STATE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .preq_o     (preq_o),
  .pstate_o   (pstate_o),
  .paccept_i  (paccept_i),
  .pdeny_i    (pdeny_i),
  .cur_state_o(cur_state_o),
  .done_o     (done_o),
  .denied_o   (denied_o)
);

// File: tb/pwr_req_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_req_ctrl_bench;
  localparam int unsigned M = 2, N = 3, TINIT = 8, INIT_STATE = 1;

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic         start_i = 1'b0, auto_en_i = 1'b0;
  logic [M-1:0] target_i = '0;
  logic [N-1:0] pactive_i = '0;
  logic         paccept_i = 1'b0, pdeny_i = 1'b0;
  logic         preq_o, done_o, denied_o;
  logic [M-1:0] pstate_o, cur_state_o;

  int n_chk = 0, n_bad = 0;
  bit dev_deny = 1'b0;
  int dev_dly  = 1;
  int seed_v;

  always #4 clk_i = ~clk_i;

  pwr_req_ctrl #(.M(M), .N(N), .TINIT(TINIT), .INIT_STATE(INIT_STATE)) u_pwr_req_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .target_i(target_i),
    .auto_en_i(auto_en_i), .pactive_i(pactive_i), .preq_o(preq_o),
    .pstate_o(pstate_o), .paccept_i(paccept_i), .pdeny_i(pdeny_i),
    .cur_state_o(cur_state_o), .done_o(done_o), .denied_o(denied_o)
  );

  function automatic logic [M-1:0] exp_cur(logic [M-1:0] old, logic [M-1:0] tgt, bit deny);
    return deny ? old : tgt;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  // device model: answers a high request, releases after the request drops
  initial begin
    int wait_n = 0;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        paccept_i = 1'b0; pdeny_i = 1'b0; wait_n = dev_dly;
      end else if (preq_o && !paccept_i && !pdeny_i) begin
        if (wait_n != 0) wait_n--;
        else begin
          if (dev_deny) pdeny_i = 1'b1; else paccept_i = 1'b1;
          wait_n = dev_dly;
        end
      end else if (!preq_o && (paccept_i || pdeny_i)) begin
        if (wait_n != 0) wait_n--;
        else begin
          paccept_i = 1'b0; pdeny_i = 1'b0; wait_n = dev_dly;
        end
      end
    end
  end

  // called with preq_o just seen high carrying tgt
  task automatic finish_hs(input logic [M-1:0] tgt, input bit deny, input logic [M-1:0] old);
    while (!(paccept_i || pdeny_i)) begin
      chk(pstate_o == tgt, "R3 pstate held", pstate_o, tgt);
      step();
    end
    step();
    chk(preq_o == 1'b0, "R5 preq falls", preq_o, 0);
    if (deny) chk(pstate_o == old, "R6 revert", pstate_o, old);
    while (!(done_o || denied_o)) step();
    if (deny) begin
      chk(denied_o && !done_o, "R6 denied pulse", denied_o, 1);
    end else begin
      chk(done_o && !denied_o, "R7 done pulse", done_o, 1);
    end
    chk(cur_state_o == exp_cur(old, tgt, deny), "R7 cur_state", cur_state_o, exp_cur(old, tgt, deny));
    step();
    chk(!done_o && !denied_o, "R7 single pulse", {done_o, denied_o}, 0);
  endtask

  task automatic do_req(input logic [M-1:0] tgt, input bit deny, input int dly);
    logic [M-1:0] old;
    old = cur_state_o;
    dev_deny = deny; dev_dly = dly;
    chk(!paccept_i && !pdeny_i, "R4 quiet before launch", {paccept_i, pdeny_i}, 0);
    start_i = 1'b1; target_i = tgt;
    step();
    start_i = 1'b0;
    chk(preq_o && pstate_o == tgt, "R3 launch", {preq_o, pstate_o}, {1'b1, tgt});
    finish_hs(tgt, deny, old);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'h5eed);
    // R1 reset state
    repeat (3) step();
    chk(!preq_o && !done_o && !denied_o, "R1 outputs low", {preq_o, done_o, denied_o}, 0);
    chk(pstate_o == INIT_STATE && cur_state_o == INIT_STATE, "R1 init state", pstate_o, INIT_STATE);
    // R2 tinit with start held; R8 stored request launches afterwards
    dev_deny = 1'b0; dev_dly = 1;
    start_i = 1'b1; target_i = 2'd3;
    @(negedge clk_i); rst_ni = 1'b1; #1;
    for (int k = 0; k < int'(TINIT); k++) begin
      step();
      chk(!preq_o && pstate_o == INIT_STATE, "R2 tinit hold", {preq_o, pstate_o}, INIT_STATE);
    end
    start_i = 1'b0;
    step();
    chk(preq_o && pstate_o == 2'd3, "R8 stored start after tinit", pstate_o, 3);
    finish_hs(2'd3, 1'b0, 2'(INIT_STATE));

    // directed grant and refusal
    do_req(2'd0, 1'b0, 0);
    do_req(2'd2, 1'b1, 2);
    do_req(2'd1, 1'b1, 0);

    // R8: requests during an open handshake, newest kept
    dev_deny = 1'b0; dev_dly = 4;
    start_i = 1'b1; target_i = 2'd1;
    step();
    start_i = 1'b1; target_i = 2'd2;
    step();
    start_i = 1'b1; target_i = 2'd3;
    step();
    start_i = 1'b0;
    while (!(paccept_i || pdeny_i)) step();
    while (preq_o || paccept_i) begin
      chk(!preq_o, "R4 no launch while accept high", preq_o, 0);
      step();
    end
    while (!preq_o) step();
    chk(pstate_o == 2'd3, "R8 newest stored target", pstate_o, 3);
    chk(cur_state_o == 2'd1, "R7 first grant", cur_state_o, 1);
    finish_hs(2'd3, 1'b0, 2'd1);

    // R9 activity-driven requests
    dev_dly = 1;
    auto_en_i = 1'b1; pactive_i = 3'b110;
    step();
    chk(!preq_o, "R9 register stage", preq_o, 0);
    step();
    chk(preq_o && pstate_o == 2'd2, "R9 highest bit", pstate_o, 2);
    finish_hs(2'd2, 1'b0, 2'd3);
    repeat (3) begin
      step();
      chk(!preq_o, "R9 no request when already there", preq_o, 0);
    end
    pactive_i = 3'b001; start_i = 1'b1; target_i = 2'd3;
    step();
    start_i = 1'b0;
    chk(preq_o && pstate_o == 2'd3, "R9 start precedence", pstate_o, 3);
    finish_hs(2'd3, 1'b0, 2'd2);
    step();
    chk(preq_o && pstate_o == 2'd0, "R9 follow-up auto", pstate_o, 0);
    auto_en_i = 1'b0;
    finish_hs(2'd0, 1'b0, 2'd3);
    repeat (2) step();

    // random mix
    for (int i = 0; i < 40; i++) begin
      do_req(2'($urandom % 4), 1'($urandom % 2), int'($urandom % 4));
      repeat (int'($urandom % 3)) step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule